// File: doc/BRIEF.md
# Trace and Floating-Point Assist Exception Entry

This block sits at the retirement point of a processor core. For each retired instruction it decides whether a trace exception (single-step or branch-trace) or a floating-point assist exception has to be taken. When one is taken, it builds the complete set of values for exception entry: the handler address, the two save/restore registers and the new machine state.

Retirements arrive on a valid/ready stream. A retirement that does not cause an exception is consumed and produces no output. A retirement that causes an exception produces one entry record on a registered valid/ready output stream. While a record is waiting and the consumer holds `exc_ready` low, the record stays stable and `ret_ready` is held low. This is the back-pressure the block applies, so no retirement is lost. The record of an accepted retirement appears on the output after one clock edge. Machine-state bits in this description use LSB-0 numbering: bit 0 is the least significant bit.

Top module: `exc_entry_top`

## Requirements
- R1: A trace entry is produced when single-step enable `msr_in[10]` is 1 and the retired instruction is not a return-from-interrupt (`ret_is_rfi`=0).
- R2: A trace entry is produced when branch-trace enable `msr_in[9]` is 1 and `ret_is_branch` is 1. With only `msr_in[9]` set, a non-branch instruction produces no entry.
- R3: No trace entry follows an instruction that raised its own exception (`ret_faulted`=1).
- R4: An FP assist entry is produced when all of the following hold: some bit of `fp_flags & fp_enables` is 1, `fp_summary` is 1, either `msr_in[11]` or `msr_in[8]` is 1, and `fp_summary_by_move` is 0. If either mode bit is missing or `fp_summary_by_move` is 1, no entry is produced.
- R5: An FP assist entry is also produced when `fp_underflow` is 1 while the underflow enable `fp_enables[2]` is 0. It is also produced when `fp_denorm` is 1.
- R6: When trace and FP assist are both requested, exactly one entry is produced, of kind FP assist (`exc_kind`=1; trace is 0).
- R7: `exc_vector` is the base plus 0x00D00 for trace or 0x00E00 for FP assist. The base is 0xFFF00000 when the prefix bit `msr_in[6]` is 1 and 0 otherwise.
- R8: `exc_srr0` equals `ret_next_ea` of the retirement that caused the entry.
- R9: `exc_srr1` equals `msr_in` with bits 30:27 and 21:16 forced to 0. As a result, bit 1 is 0 only when `msr_in[1]` is 0.
- R10: `exc_msr` keeps bits 12 and 6 of `msr_in`, sets bit 0 to `msr_in[16]`, and clears every other bit.
- R11: While `exc_valid`=1 and `exc_ready`=0, the record is held unchanged and `ret_ready` is 0. A retirement that causes no exception produces no output.
- R12: After reset `exc_valid` is 0 and `ret_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Retirement record valid |
| ret_ready | output | 1 | Block can accept a retirement |
| ret_next_ea | input | 32 | Address of the instruction after the retired one |
| ret_is_branch | input | 1 | Retired instruction is a branch |
| ret_is_rfi | input | 1 | Retired instruction is a return-from-interrupt |
| ret_faulted | input | 1 | Retired instruction raised its own exception |
| fp_flags | input | 5 | FP exception condition bits |
| fp_enables | input | 5 | FP exception enable bits, bit 2 is underflow enable |
| fp_summary | input | 1 | Enabled-exception summary |
| fp_summary_by_move | input | 1 | Summary was set by a move or return-from-interrupt |
| fp_underflow | input | 1 | Intermediate result underflowed |
| fp_denorm | input | 1 | Denormalized source needs assistance |
| msr_in | input | 32 | Current machine state |
| exc_valid | output | 1 | Entry record valid |
| exc_ready | input | 1 | Consumer accepts the entry record |
| exc_kind | output | 1 | 0 trace, 1 FP assist |
| exc_vector | output | 32 | Handler address |
| exc_srr0 | output | 32 | Save/restore register 0 value |
| exc_srr1 | output | 32 | Save/restore register 1 value |
| exc_msr | output | 32 | New machine state |

## Verification
The only state is the output record register. If it is corrupted or its valid bit is wrong, the port shows a stale or missing entry one edge after the retirement that should have produced it, or a duplicate entry one edge after the record should have drained. A wrong hold under back-pressure shows as a change in `exc_srr0` or `exc_vector` while `exc_ready` is low, on the very next edge. Detection and state-building errors show as a wrong kind, a wrong vector or wrong bits in the record on the first entry they affect.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 32;
  localparam int FPW  = 5;

  // LSB-0 machine state bit positions
  localparam int MS_LE   = 0;
  localparam int MS_RI   = 1;
  localparam int MS_PFX  = 6;
  localparam int MS_FM1  = 8;
  localparam int MS_BTR  = 9;
  localparam int MS_STEP = 10;
  localparam int MS_FM0  = 11;
  localparam int MS_MCE  = 12;
  localparam int MS_ILE  = 16;
  localparam int FP_UNDER_EN = 2;

  localparam logic [XLEN-1:0] SRR1_CLR_MASK = 32'h783F_0000;

  typedef enum logic {KIND_TRACE = 1'b0, KIND_FPA = 1'b1} exc_kind_e;

  typedef struct packed {
    exc_kind_e       kind;
    logic [XLEN-1:0] vector;
    logic [XLEN-1:0] srr0;
    logic [XLEN-1:0] srr1;
    logic [XLEN-1:0] msr;
  } entry_rec_t;
endpackage

// File: rtl/exc_detect.sv
module exc_detect
  import exc_entry_pkg::*;
(
  input  logic           step_en,
  input  logic           btr_en,
  input  logic           fm0,
  input  logic           fm1,
  input  logic           is_branch,
  input  logic           is_rfi,
  input  logic           faulted,
  input  logic [FPW-1:0] flags,
  input  logic [FPW-1:0] enables,
  input  logic           summary,
  input  logic           summary_by_move,
  input  logic           underflow,
  input  logic           denorm,
  output logic           trace_req,
  output logic           fpa_req
);
  logic step_hit, branch_hit, enabled_hit, under_hit;

  always_comb begin
    step_hit    = step_en && !is_rfi;
    branch_hit  = btr_en && is_branch;
    trace_req   = !faulted && (step_hit || branch_hit);
    enabled_hit = (|(flags & enables)) && summary && (fm0 || fm1) && !summary_by_move;
    under_hit   = underflow && !enables[FP_UNDER_EN];
    fpa_req     = enabled_hit || under_hit || denorm;
  end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] HI_BASE   = 32'hFFF0_0000,
  parameter logic [XLEN-1:0] TRACE_OFS = 32'h0000_0D00,
  parameter logic [XLEN-1:0] FPA_OFS   = 32'h0000_0E00
) (
  input  exc_kind_e       kind,
  input  logic [XLEN-1:0] msr,
  input  logic [XLEN-1:0] next_ea,
  output entry_rec_t      rec
);
  logic [XLEN-1:0] base, ofs, new_msr;

  always_comb begin
    base = msr[MS_PFX] ? HI_BASE : '0;
    ofs  = (kind == KIND_FPA) ? FPA_OFS : TRACE_OFS;
    new_msr          = '0;
    new_msr[MS_PFX]  = msr[MS_PFX];
    new_msr[MS_MCE]  = msr[MS_MCE];
    new_msr[MS_LE]   = msr[MS_ILE];
    rec.kind   = kind;
    rec.vector = base + ofs;
    rec.srr0   = next_ea;
    rec.srr1   = msr & ~SRR1_CLR_MASK;
    rec.msr    = new_msr;
  end
endmodule

// File: rtl/exc_out_stage.sv
module exc_out_stage
  import exc_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_take,
  input  entry_rec_t in_rec,
  output logic       out_valid,
  input  logic       out_ready,
  output entry_rec_t out_rec
);
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rec   <= '0;
    end else if (accept) begin
      out_valid <= in_take;
      if (in_take) out_rec <= in_rec;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rec));
endmodule

// File: rtl/exc_entry_top.sv
module exc_entry_top
  import exc_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ret_valid,
  output logic        ret_ready,
  input  logic [31:0] ret_next_ea,
  input  logic        ret_is_branch,
  input  logic        ret_is_rfi,
  input  logic        ret_faulted,
  input  logic [4:0]  fp_flags,
  input  logic [4:0]  fp_enables,
  input  logic        fp_summary,
  input  logic        fp_summary_by_move,
  input  logic        fp_underflow,
  input  logic        fp_denorm,
  input  logic [31:0] msr_in,
  output logic        exc_valid,
  input  logic        exc_ready,
  output logic        exc_kind,
  output logic [31:0] exc_vector,
  output logic [31:0] exc_srr0,
  output logic [31:0] exc_srr1,
  output logic [31:0] exc_msr
);
  logic       trace_req, fpa_req, take;
  exc_kind_e  kind;
  entry_rec_t rec_next, rec_q;

  exc_detect u_detect (
    .step_en(msr_in[MS_STEP]), .btr_en(msr_in[MS_BTR]),
    .fm0(msr_in[MS_FM0]), .fm1(msr_in[MS_FM1]),
    .is_branch(ret_is_branch), .is_rfi(ret_is_rfi), .faulted(ret_faulted),
    .flags(fp_flags), .enables(fp_enables), .summary(fp_summary),
    .summary_by_move(fp_summary_by_move), .underflow(fp_underflow),
    .denorm(fp_denorm), .trace_req(trace_req), .fpa_req(fpa_req)
  );

  // FP assist wins over trace when both fire
  assign kind = fpa_req ? KIND_FPA : KIND_TRACE;
  assign take = trace_req || fpa_req;

  exc_entry_calc u_calc (
    .kind(kind), .msr(msr_in), .next_ea(ret_next_ea), .rec(rec_next)
  );

  exc_out_stage u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ret_valid), .in_ready(ret_ready),
    .in_take(take), .in_rec(rec_next),
    .out_valid(exc_valid), .out_ready(exc_ready), .out_rec(rec_q)
  );

  assign exc_kind   = rec_q.kind;
  assign exc_vector = rec_q.vector;
  assign exc_srr0   = rec_q.srr0;
  assign exc_srr1   = rec_q.srr1;
  assign exc_msr    = rec_q.msr;

  // R3
  faulted_no_trace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && ret_ready && ret_faulted && !fpa_req |=> !exc_valid);
  // R6
  fpa_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && ret_ready && fpa_req |=> exc_valid && exc_kind);
  // R7
  vector_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> exc_vector[11:0] == (exc_kind ? 12'hE00 : 12'hD00));
  // R9
  srr1_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_srr1 & SRR1_CLR_MASK) == '0);
  // R10
  msr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_msr & ~32'h0000_1041) == '0);
  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !exc_ready |-> !ret_ready);
endmodule

// File: tb/exc_entry_tb.sv
module exc_entry_top_tb_top;
  logic clk = 0, rst_n = 0;
  logic ret_valid = 0, ret_ready;
  logic [31:0] ret_next_ea = 0;
  logic ret_is_branch = 0, ret_is_rfi = 0, ret_faulted = 0;
  logic [4:0] fp_flags = 0, fp_enables = 0;
  logic fp_summary = 0, fp_summary_by_move = 0, fp_underflow = 0, fp_denorm = 0;
  logic [31:0] msr_in = 0;
  logic exc_valid, exc_ready = 1, exc_kind;
  logic [31:0] exc_vector, exc_srr0, exc_srr1, exc_msr;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  exc_entry_top dut_i (.*);

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    ret_next_ea = 0; ret_is_branch = 0; ret_is_rfi = 0; ret_faulted = 0;
    fp_flags = 0; fp_enables = 0; fp_summary = 0; fp_summary_by_move = 0;
    fp_underflow = 0; fp_denorm = 0; msr_in = 0;
  endtask

  // one retirement; returns at the negedge after the accepting edge
  task automatic retire();
    @(negedge clk); ret_valid = 1;
    @(posedge clk); #1 ret_valid = 0;
    @(negedge clk);
  endtask

  task automatic expect_none(input string tag);
    chk(exc_valid == 0, tag, {31'b0, exc_valid}, 0);
    @(posedge clk); clear_in();
  endtask

  task automatic expect_entry(input string tag, input bit kind, input logic [31:0] vec,
                              input logic [31:0] ea, input logic [31:0] msr);
    chk(exc_valid == 1, {tag, " valid"}, {31'b0, exc_valid}, 1);
    chk(exc_kind == kind, {tag, " kind"}, {31'b0, exc_kind}, {31'b0, kind});
    chk(exc_vector == vec, {tag, " vector"}, exc_vector, vec);
    chk(exc_srr0 == ea, {tag, " srr0"}, exc_srr0, ea);
    chk(exc_srr1 == (msr & ~32'h783F_0000), {tag, " srr1"}, exc_srr1, msr & ~32'h783F_0000);
    chk(exc_msr == ((msr & 32'h0000_1040) | {31'b0, msr[16]}), {tag, " msr"}, exc_msr,
        (msr & 32'h0000_1040) | {31'b0, msr[16]});
    @(posedge clk); clear_in();
  endtask

  task automatic t_reset();
    chk(exc_valid == 0, "R12 valid", {31'b0, exc_valid}, 0);
    chk(ret_ready == 1, "R12 ready", {31'b0, ret_ready}, 1);
  endtask

  task automatic t_step();
    msr_in = 32'h0000_0400; ret_next_ea = 32'h0000_1004; retire();
    expect_entry("R1 step", 0, 32'h0000_0D00, 32'h0000_1004, 32'h0000_0400);
    msr_in = 32'h0000_0400; ret_is_rfi = 1; retire();
    expect_none("R1 rfi no trace");
  endtask

  task automatic t_branch();
    msr_in = 32'h0000_0200; ret_is_branch = 1; ret_next_ea = 32'h0000_2000; retire();
    expect_entry("R2 branch", 0, 32'h0000_0D00, 32'h0000_2000, 32'h0000_0200);
    msr_in = 32'h0000_0200; retire();
    expect_none("R2 non-branch");
    msr_in = 32'h0000_0600; ret_faulted = 1; ret_is_branch = 1; retire();
    expect_none("R3 faulted");
  endtask

  task automatic t_fp_enabled();
    msr_in = 32'h0000_0800; fp_flags = 5'b01000; fp_enables = 5'b01000; fp_summary = 1;
    ret_next_ea = 32'h0000_3000; retire();
    expect_entry("R4 fe0", 1, 32'h0000_0E00, 32'h0000_3000, 32'h0000_0800);
    msr_in = 32'h0000_0100; fp_flags = 5'b00001; fp_enables = 5'b00001; fp_summary = 1;
    ret_next_ea = 32'h0000_3004; retire();
    expect_entry("R4 fe1", 1, 32'h0000_0E00, 32'h0000_3004, 32'h0000_0100);
    fp_flags = 5'b00001; fp_enables = 5'b00001; fp_summary = 1; retire();
    expect_none("R4 no mode bit");
    msr_in = 32'h0000_0800; fp_flags = 5'b00001; fp_enables = 5'b00001; fp_summary = 1;
    fp_summary_by_move = 1; retire();
    expect_none("R4 by move");
    msr_in = 32'h0000_0800; fp_flags = 5'b00001; fp_enables = 5'b00010; fp_summary = 1; retire();
    expect_none("R4 disabled cond");
  endtask

  task automatic t_fp_other();
    fp_underflow = 1; fp_enables = 5'b11011; ret_next_ea = 32'h0000_4000; retire();
    expect_entry("R5 underflow", 1, 32'h0000_0E00, 32'h0000_4000, 32'h0);
    fp_underflow = 1; fp_enables = 5'b00100; retire();
    expect_none("R5 underflow enabled");
    fp_denorm = 1; ret_next_ea = 32'h0000_4008; retire();
    expect_entry("R5 denorm", 1, 32'h0000_0E00, 32'h0000_4008, 32'h0);
  endtask

  task automatic t_priority();
    msr_in = 32'h0000_0400; fp_denorm = 1; ret_next_ea = 32'h0000_5000; retire();
    expect_entry("R6 both", 1, 32'h0000_0E00, 32'h0000_5000, 32'h0000_0400);
    @(negedge clk);
    chk(exc_valid == 0, "R6 single entry", {31'b0, exc_valid}, 0);
  endtask

  task automatic t_state();
    msr_in = 32'hFFFF_FFFF; ret_next_ea = 32'hABCD_0010; retire();
    expect_entry("R7 R9 R10 all ones", 0, 32'hFFF0_0D00, 32'hABCD_0010, 32'hFFFF_FFFF);
    msr_in = 32'h0001_0400; ret_next_ea = 32'h0000_6000; retire();
    expect_entry("R10 ile", 0, 32'h0000_0D00, 32'h0000_6000, 32'h0001_0400);
    msr_in = 32'h0000_0440; fp_denorm = 1; ret_next_ea = 32'h0000_6004; retire();
    expect_entry("R7 R8 hi fpa", 1, 32'hFFF0_0E00, 32'h0000_6004, 32'h0000_0440);
    msr_in = 32'h0000_0402; ret_next_ea = 32'h0000_6008; retire();
    chk(exc_srr1[1] == 1, "R9 ri kept", {31'b0, exc_srr1[1]}, 1);
    @(posedge clk); clear_in();
  endtask

  task automatic t_backpressure();
    @(negedge clk); exc_ready = 0;
    msr_in = 32'h0000_0400; ret_next_ea = 32'h0000_7000; retire();
    chk(exc_valid == 1, "R11 first valid", {31'b0, exc_valid}, 1);
    ret_next_ea = 32'h0000_7004; ret_valid = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(exc_srr0 == 32'h0000_7000, "R11 held", exc_srr0, 32'h0000_7000);
    chk(ret_ready == 0, "R11 ready low", {31'b0, ret_ready}, 0);
    exc_ready = 1;
    @(posedge clk); #1 ret_valid = 0;
    @(negedge clk);
    chk(exc_valid == 1 && exc_srr0 == 32'h0000_7004, "R11 second", exc_srr0, 32'h0000_7004);
    @(posedge clk); @(negedge clk);
    chk(exc_valid == 0, "R11 drained", {31'b0, exc_valid}, 0);
    clear_in();
    retire();
    expect_none("R11 no-exception retire");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_step();
    t_branch();
    t_fp_enabled();
    t_fp_other();
    t_priority();
    t_state();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule